// File: doc/BRIEF.md
# LFSR Keystream Byte Encryptor

This block is a sequencing controller that sits in front of a byte-wide, single-port data memory with a one-cycle read latency. A one-cycle pulse on `start` makes it fetch three configuration bytes from fixed addresses: a pad count, a feedback mask and a seed. It loads a 6-bit linear feedback shift register with the seed and then produces a 64-byte ciphertext block. Each ciphertext byte is a plaintext byte XORed with the current register state. Before the message proper, the block emits a run of pad characters, and these are encrypted like any other byte.

Both the feedback mask and the seed are runtime data, so one netlist serves any key. The memory itself sits outside the block. The block drives one address, a write strobe and write data, and it receives read data one cycle after the address it presented. Plaintext lives at addresses 0 upward and the ciphertext goes to 64..127. When the last byte has been written, `done` rises and stays high until the next `start`.

Top module: `lxe_encryptor`

## Requirements
- R1: While `rst_n` is low and after reset, `done` is 0 and `mem_we` is 0 until a `start` pulse is seen.
- R2: The three cycles that follow the `start` edge present addresses 61, 62 and 63 in that order. Address 61 holds the pad count (8 bits), address 62 holds the feedback mask (low 6 bits) and address 63 holds the seed (low 6 bits).
- R3: The key register steps as next = {state[4:0], parity(state AND mask)}, so the new bit enters at bit 0.
- R4: Output byte k equals its source byte XOR {2'b00, key}, where key is the register state after k steps from the seed. The register steps exactly once per output byte.
- R5: For k below the pad count, the source byte is 0x5F. Otherwise the source byte is the plaintext at address k − pad count.
- R6: Exactly 64 writes are made, to addresses 64, 65, … 127 in ascending order, and no two writes fall on adjacent cycles.
- R7: `done` rises after the 64th write and holds, with no further writes, until the next `start`. The `start` edge clears it.
- R8: A seed of zero is used unchanged, so the key stays zero and the ciphertext equals the source bytes.
- R9: A pad count of 64 or more makes every output byte a pad character, and no plaintext is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to encrypt a block |
| mem_addr | output | 7 | Memory address for read or write |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| done | output | 1 | Block finished, held until the next start |

## Verification
The bench checks the boundary between pad and message. A controller with an off-by-one error at that boundary would either emit one pad byte too many or fetch the plaintext from the wrong base, and the first message byte would then mismatch. A pad count above the block length must never make the controller fetch from a wrapped, negative offset. A zero seed must stay locked at zero, and a design that forced it nonzero would scramble the copy. Zero and full feedback masks exercise the parity rule at both extremes. The bench also holds the block idle after completion to catch a stray write or a `done` flag that drops early.

// File: rtl/lxe_pkg.sv
package lxe_pkg;
   localparam int DATA_W   = 8;
   localparam int ADDR_W   = 7;
   localparam int LFSR_W   = 6;
   localparam int MSG_LEN  = 64;
   localparam int OUT_BASE = 64;
   localparam int CFG_PAD  = 61;
   localparam int CFG_MASK = 62;
   localparam int CFG_SEED = 63;
   localparam logic [7:0] PAD_CHAR = 8'h5F;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CFG_PAD,
      ST_CFG_MASK,
      ST_CFG_SEED,
      ST_SEED,
      ST_FETCH,
      ST_WRITE,
      ST_DONE
   } lxe_state_e;
endpackage

// File: rtl/lxe_lfsr.sv
module lxe_lfsr #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   input  logic [W-1:0] mask,
   output logic [W-1:0] state
);
   if (W < 2) begin : g_bad_w
      $error("lxe_lfsr: W must be at least 2");
   end

   logic fb;
   assign fb = ^(state & mask);

   always_ff @(posedge clk) begin
      if (!rst_n)     state <= '0;
      else if (load)  state <= seed;
      else if (step)  state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/lxe_cfg_regs.sv
module lxe_cfg_regs #(
   parameter int DATA_W = 8,
   parameter int LFSR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_pad,
   input  logic              cap_mask,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] pad_len,
   output logic [LFSR_W-1:0] fb_mask
);
   if (LFSR_W > DATA_W) begin : g_bad_w
      $error("lxe_cfg_regs: LFSR_W exceeds DATA_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pad_len <= '0;
         fb_mask <= '0;
      end else begin
         if (cap_pad)  pad_len <= rdata;
         if (cap_mask) fb_mask <= rdata[LFSR_W-1:0];
      end
   end
endmodule

// File: rtl/lxe_idx_ctr.sv
module lxe_idx_ctr #(
   parameter int LEN = 64,
   localparam int W  = (LEN > 1) ? $clog2(LEN) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] idx,
   output logic         last
);
   if (LEN < 2) begin : g_bad_len
      $error("lxe_idx_ctr: LEN must be at least 2");
   end

   assign last = (idx == W'(LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    idx <= '0;
      else if (clr)  idx <= '0;
      else if (inc)  idx <= idx + 1'b1;
   end
endmodule

// File: rtl/lxe_encryptor.sv
module lxe_encryptor
   import lxe_pkg::*;
#(
   parameter int DATA_W   = lxe_pkg::DATA_W,
   parameter int ADDR_W   = lxe_pkg::ADDR_W,
   parameter int LFSR_W   = lxe_pkg::LFSR_W,
   parameter int MSG_LEN  = lxe_pkg::MSG_LEN,
   parameter int OUT_BASE = lxe_pkg::OUT_BASE,
   parameter int CFG_PAD  = lxe_pkg::CFG_PAD,
   parameter int CFG_MASK = lxe_pkg::CFG_MASK,
   parameter int CFG_SEED = lxe_pkg::CFG_SEED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done
);
   localparam int IDX_W = $clog2(MSG_LEN);

   if (OUT_BASE + MSG_LEN > (1 << ADDR_W)) begin : g_bad_out
      $error("lxe_encryptor: output region exceeds address space");
   end
   if (CFG_SEED >= (1 << ADDR_W) || CFG_PAD >= (1 << ADDR_W) || CFG_MASK >= (1 << ADDR_W)) begin : g_bad_cfg
      $error("lxe_encryptor: configuration address out of range");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("lxe_encryptor: message index wider than data");
   end

   lxe_state_e st, st_nx;

   logic [DATA_W-1:0] pad_len;
   logic [LFSR_W-1:0] fb_mask;
   logic [LFSR_W-1:0] key;
   logic [DATA_W-1:0] key_ext;
   logic [IDX_W-1:0]  idx;
   logic              idx_last;
   logic              in_pad;
   logic [DATA_W-1:0] src;

   lxe_cfg_regs #(.DATA_W(DATA_W), .LFSR_W(LFSR_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_pad  (st == ST_CFG_MASK),
      .cap_mask (st == ST_CFG_SEED),
      .rdata    (mem_rdata),
      .pad_len  (pad_len),
      .fb_mask  (fb_mask)
   );

   lxe_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st == ST_SEED),
      .step  (st == ST_WRITE),
      .seed  (mem_rdata[LFSR_W-1:0]),
      .mask  (fb_mask),
      .state (key)
   );

   lxe_idx_ctr #(.LEN(MSG_LEN)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st == ST_SEED),
      .inc   (st == ST_WRITE),
      .idx   (idx),
      .last  (idx_last)
   );

   if (DATA_W == LFSR_W) begin : g_key_same
      assign key_ext = key;
   end else if (DATA_W > LFSR_W) begin : g_key_zext
      assign key_ext = {{(DATA_W - LFSR_W){1'b0}}, key};
   end else begin : g_key_bad
      $error("lxe_encryptor: LFSR_W exceeds DATA_W");
   end

   assign in_pad    = (DATA_W'(idx) < pad_len);
   assign src       = in_pad ? DATA_W'(PAD_CHAR) : mem_rdata;
   assign mem_wdata = src ^ key_ext;
   assign mem_we    = (st == ST_WRITE);
   assign done      = (st == ST_DONE);

   always_comb begin
      unique case (st)
         ST_CFG_PAD:  mem_addr = ADDR_W'(CFG_PAD);
         ST_CFG_MASK: mem_addr = ADDR_W'(CFG_MASK);
         ST_CFG_SEED: mem_addr = ADDR_W'(CFG_SEED);
         ST_FETCH:    mem_addr = in_pad ? '0 : ADDR_W'(DATA_W'(idx) - pad_len);
         ST_WRITE:    mem_addr = ADDR_W'(OUT_BASE) + ADDR_W'(idx);
         default:     mem_addr = '0;
      endcase
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE, ST_DONE: if (start) st_nx = ST_CFG_PAD;
         ST_CFG_PAD:       st_nx = ST_CFG_MASK;
         ST_CFG_MASK:      st_nx = ST_CFG_SEED;
         ST_CFG_SEED:      st_nx = ST_SEED;
         ST_SEED:          st_nx = ST_FETCH;
         ST_FETCH:         st_nx = ST_WRITE;
         ST_WRITE:         st_nx = idx_last ? ST_DONE : ST_FETCH;
         default:          st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end
endmodule

// File: rtl/lxe_checker.sv
module lxe_checker #(
   parameter int ADDR_W   = 7,
   parameter int OUT_BASE = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam logic [ADDR_W-1:0] OB = ADDR_W'(OUT_BASE);

   // R1: reset holds the block quiet
   always @(negedge clk) begin
      if (!rst_n) a_r1_quiet_in_reset: assert (!mem_we && !done);
   end

   a_r6_out_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= OB));

   a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_we);

   a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
endmodule

bind lxe_encryptor lxe_checker #(.ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)) u_lxe_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .done     (done),
   .mem_we   (mem_we),
   .mem_addr (mem_addr)
);

// File: tb/lxe_encryptor_test.sv
module lxe_encryptor_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] mem_addr;
   logic       mem_we;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = 8'h00;
   logic       done;

   logic [7:0] mem [128];
   logic [7:0] exp_b [64];
   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   string cur_req = "R4";

   always #4 clk = ~clk;

   lxe_encryptor uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // per-clock comparison of every write against the reference queue
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (wr_cnt < 64) begin
            check(mem_addr == 7'(64 + wr_cnt), "R6", mem_addr, 64 + wr_cnt);
            check(mem_wdata == exp_b[wr_cnt], cur_req, mem_wdata, exp_b[wr_cnt]);
         end else begin
            check(1'b0, "R6", wr_cnt, 63);
         end
         wr_cnt++;
      end
   end

   task automatic run_case(input int pad, input int fmask, input int seed,
                           input int mbase, input string req);
      int key;
      @(negedge clk);
      for (int i = 0; i < 64; i++) mem[i] = 8'((mbase + i * 13) & 255);
      mem[61] = 8'(pad);
      mem[62] = 8'(fmask);
      mem[63] = 8'(seed);
      for (int i = 64; i < 128; i++) mem[i] = 8'hAA;
      key = seed & 63;
      for (int k = 0; k < 64; k++) begin
         int srcb;
         srcb = (k < pad) ? 8'h5F : int'(mem[k - pad]);
         exp_b[k] = 8'((srcb ^ key) & 255);
         key = ((key << 1) | ($countones(key & fmask) & 1)) & 63;
      end
      wr_cnt = 0;
      cur_req = req;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7", done, 0);
      check(mem_addr == 7'd61, "R2", mem_addr, 61);
      @(negedge clk);
      check(mem_addr == 7'd62, "R2", mem_addr, 62);
      @(negedge clk);
      check(mem_addr == 7'd63, "R2", mem_addr, 63);
      for (int c = 0; c < 400 && !done; c++) @(negedge clk);
      check(done == 1'b1, "R7", done, 1);
      check(wr_cnt == 64, "R6", wr_cnt, 64);
      begin
         int mism = 0;
         for (int i = 0; i < 64; i++) if (mem[64 + i] !== exp_b[i]) mism++;
         check(mism == 0, req, mism, 0);
      end
      repeat (5) @(negedge clk);
      check(done == 1'b1 && wr_cnt == 64, "R7", wr_cnt, 64);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0 && mem_we == 1'b0, "R1", {done, mem_we}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(done == 1'b0 && mem_we == 1'b0, "R1", {done, mem_we}, 0);
      run_case(5, 6'h21, 6'h2B, 3, "R5");
      run_case(0, 6'h30, 6'h01, 100, "R4");
      run_case(3, 6'h3F, 6'h15, 7, "R3");
      run_case(2, 6'h00, 6'h3F, 50, "R3");
      run_case(4, 6'h2D, 6'h00, 9, "R8");
      run_case(70, 6'h36, 6'h0F, 1, "R9");
      run_case(63, 6'h21, 6'h11, 200, "R5");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule